// File: doc/BRIEF.md
# Inter-Port Mailbox Interrupt Controller

This block sits between two processors that share a memory device and gives them a way to signal each other. Each side owns four 16-bit mailboxes. It can write them with byte granularity and read them back. It can also read the four mailboxes owned by the other side. When a side writes the upper byte of one of its own mailboxes, an interrupt source is raised toward the other side. The receiving side acknowledges that source by reading the upper byte of the same mailbox. The acknowledge leaves the mailbox data untouched.

Every side also has a control word. It holds a 4-bit enable mask, an active-low cause field and an active-low status field. The cause field records only unmasked events and drives the interrupt output. The status field records every event, whether masked or not. The block is fully synchronous. A mailbox access is acted on once, in the clock cycle where the side's select input is first seen low while its memory enable is low.

Top module: `mbx_pair`

## Requirements
- R1: A side's access is decoded only while its select input `*_sel_n` is 0 and its memory enable `*_mem_en` is 0. With memory enable at 1, a write changes nothing and a read returns 0x0000.
- R2: Address 0x20+i (i = 0..3) is the side's own mailbox i. A write updates bits 15:8 when `*_ub` is 1 and bits 7:0 when `*_lb` is 1. A read returns the full stored word.
- R3: A write to an own mailbox i with `*_ub` at 1 sets source i on the opposite side. A write with only `*_lb` at 1 sets nothing.
- R4: Reading an own mailbox leaves the interrupt state of both sides unchanged.
- R5: Address 0x24+i reads the opposite side's mailbox i. With `*_ub` at 1, the read clears the reader's own cause bit i and status bit i and leaves the data unchanged. A read with only `*_lb` at 1 clears nothing.
- R6: Writes and acknowledges act only on the falling transition of `*_sel_n`. Changing the address while select stays low triggers no action.
- R7: Address 0x28 is the control word. Bits 3:0 are the mask, where 1 disables a source. Bits 7:4 are the inverted cause bits and bits 11:8 the inverted status bits. Bits 15:12 read as 0. The mask is written as a whole, and only when `*_lb` is 1.
- R8: A source that is masked when it is set updates its status bit but not its cause bit. Clearing the mask afterwards does not create a cause bit.
- R9: Any other address is reserved. Writes to it change no state and reads from it return 0x0000.
- R10: `*_irq_n` is 0 exactly while at least one cause bit of that side is pending.
- R11: Synchronous reset sets all mask bits to 1, clears all cause and status bits and all mailboxes, and drives both interrupt outputs to 1. The control word then reads 0x0FFF.
- R12: When one side sets source i in the same cycle as the receiving side acknowledges source i, the set takes effect and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Side A mailbox select, active low |
| a_mem_en | input | 1 | Side A memory enable; mailbox access needs 0 |
| a_addr | input | 6 | Side A mailbox address |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_ub | input | 1 | Side A upper byte enable |
| a_lb | input | 1 | Side A lower byte enable |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_sel_n | input | 1 | Side B mailbox select, active low |
| b_mem_en | input | 1 | Side B memory enable; mailbox access needs 0 |
| b_addr | input | 6 | Side B mailbox address |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_ub | input | 1 | Side B upper byte enable |
| b_lb | input | 1 | Side B lower byte enable |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
Two events can land on the same interrupt source in one cycle. One is side A raising source i on side B by writing the upper byte of A's mailbox i. The other is side B acknowledging source i by reading that upper byte. The bench first leaves source 2 pending on side B. It then drops both selects on the same falling clock edge, with A writing mailbox 2's upper byte and B reading it. It judges the outcome from B's interrupt output, which must stay low, and from B's control word, which must still show cause and status bit 2 pending. A later acknowledge from B on its own must then release the interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_OWN  = 3'd1,
      RG_PEER = 3'd2,
      RG_CTRL = 3'd3,
      RG_RESV = 3'd4
   } region_e;

   localparam int SIDES = 2;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_BOX   = 4,
   parameter int IDX_W     = 2,
   parameter int OWN_BASE  = 32,
   parameter int PEER_BASE = 36,
   parameter int CTRL_ADDR = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_n,
   input  logic              mem_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              stb,
   output region_e           region,
   output logic [IDX_W-1:0]  idx
);

   localparam int OWN_END  = OWN_BASE + NUM_BOX;
   localparam int PEER_END = PEER_BASE + NUM_BOX;

   logic        sel_q;
   logic [31:0] a_ext;

   assign a_ext = 32'(addr);

   // Previous select level, used to find the falling transition.
   always_ff @(posedge clk) begin
      if (rst) sel_q <= 1'b1;
      else     sel_q <= sel_n;
   end

   assign stb = sel_q & ~sel_n & ~mem_en;

   always_comb begin
      region = RG_NONE;
      idx    = '0;
      if (!sel_n && !mem_en) begin
         if (a_ext >= 32'(OWN_BASE) && a_ext < 32'(OWN_END)) begin
            region = RG_OWN;
            idx    = IDX_W'(a_ext - 32'(OWN_BASE));
         end else if (a_ext >= 32'(PEER_BASE) && a_ext < 32'(PEER_END)) begin
            region = RG_PEER;
            idx    = IDX_W'(a_ext - 32'(PEER_BASE));
         end else if (a_ext == 32'(CTRL_ADDR)) begin
            region = RG_CTRL;
         end else begin
            region = RG_RESV;
         end
      end
   end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
   parameter int DATA_W  = 16,
   parameter int NUM_BOX = 4,
   parameter int IDX_W   = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 idx,
   input  logic [1:0]                       half_en,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_BOX-1:0][DATA_W-1:0]   boxes
);

   localparam int HALF = DATA_W / 2;

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
      for (genvar h = 0; h < 2; h++) begin : g_half
         logic [HALF-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)
               q <= '0;
            else if (we && idx == IDX_W'(b) && half_en[h])
               q <= wdata[h*HALF +: HALF];
         end
         assign boxes[b][h*HALF +: HALF] = q;
      end
   end

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
   parameter int NUM_BOX = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               set_ev,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               clr_ev,
   input  logic [IDX_W-1:0]   clr_idx,
   input  logic               mask_we,
   input  logic [NUM_BOX-1:0] mask_d,
   output logic [NUM_BOX-1:0] mask,
   output logic [NUM_BOX-1:0] cause,
   output logic [NUM_BOX-1:0] stat
);

   for (genvar i = 0; i < NUM_BOX; i++) begin : g_src
      logic hit_set, hit_clr;
      logic m_q, c_q, s_q;

      assign hit_set = set_ev && set_idx == IDX_W'(i);
      assign hit_clr = clr_ev && clr_idx == IDX_W'(i);

      always_ff @(posedge clk) begin
         if (rst)          m_q <= 1'b1;
         else if (mask_we) m_q <= mask_d[i];
      end

      // A set overrides a coincident acknowledge on the same source.
      always_ff @(posedge clk) begin
         if (rst) begin
            c_q <= 1'b0;
            s_q <= 1'b0;
         end else if (hit_set) begin
            s_q <= 1'b1;
            if (!m_q) c_q <= 1'b1;
         end else if (hit_clr) begin
            s_q <= 1'b0;
            c_q <= 1'b0;
         end
      end

      assign mask[i]  = m_q;
      assign cause[i] = c_q;
      assign stat[i]  = s_q;
   end

endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 6,
   parameter int NUM_BOX   = 4,
   parameter int OWN_BASE  = 32,
   parameter int PEER_BASE = 36,
   parameter int CTRL_ADDR = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              a_sel_n,
   input  logic              a_mem_en,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_wr,
   input  logic              a_ub,
   input  logic              a_lb,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq_n,
   input  logic              b_sel_n,
   input  logic              b_mem_en,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_wr,
   input  logic              b_ub,
   input  logic              b_lb,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq_n
);

   localparam int IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;

   // Elaboration-time parameter checks.
   if (NUM_BOX < 2 || (1 << IDX_W) != NUM_BOX) begin : g_bad_box
      $error("NUM_BOX must be a power of two, at least 2");
   end
   if (DATA_W % 2 != 0 || DATA_W < 3 * NUM_BOX) begin : g_bad_width
      $error("DATA_W must be even and hold mask, cause and status fields");
   end
   if (PEER_BASE < OWN_BASE + NUM_BOX && OWN_BASE < PEER_BASE + NUM_BOX) begin : g_bad_overlap
      $error("own and peer windows overlap");
   end
   if ((CTRL_ADDR >= OWN_BASE && CTRL_ADDR < OWN_BASE + NUM_BOX) ||
       (CTRL_ADDR >= PEER_BASE && CTRL_ADDR < PEER_BASE + NUM_BOX)) begin : g_bad_ctrl
      $error("control address collides with a mailbox window");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || PEER_BASE + NUM_BOX > (1 << ADDR_W) ||
       OWN_BASE + NUM_BOX > (1 << ADDR_W)) begin : g_bad_addr
      $error("address map does not fit ADDR_W");
   end

   // Per-side views, index 0 is side A and index 1 is side B.
   logic [1:0]                             sel_n_v, mem_en_v, wr_v, ub_v, lb_v;
   logic [1:0][ADDR_W-1:0]                 addr_v;
   logic [1:0][DATA_W-1:0]                 wdata_v, rd_v;
   logic [1:0]                             stb_v, own_v, peer_v, ctrl_v, resv_v, irq_n_v;
   logic [1:0][IDX_W-1:0]                  idx_v;
   logic [1:0][NUM_BOX-1:0]                mask_v, cause_v, stat_v;
   logic [1:0][NUM_BOX-1:0][DATA_W-1:0]    box_v;

   assign sel_n_v  = {b_sel_n,  a_sel_n};
   assign mem_en_v = {b_mem_en, a_mem_en};
   assign wr_v     = {b_wr,     a_wr};
   assign ub_v     = {b_ub,     a_ub};
   assign lb_v     = {b_lb,     a_lb};
   assign addr_v   = {b_addr,   a_addr};
   assign wdata_v  = {b_wdata,  a_wdata};

   for (genvar p = 0; p < SIDES; p++) begin : g_side
      localparam int Q = 1 - p;

      region_e              region;
      logic                 set_ev, clr_ev, mask_we, box_we;
      logic [DATA_W-1:0]    rd_word, ctrl_word;

      mbx_decode #(
         .ADDR_W    (ADDR_W),
         .NUM_BOX   (NUM_BOX),
         .IDX_W     (IDX_W),
         .OWN_BASE  (OWN_BASE),
         .PEER_BASE (PEER_BASE),
         .CTRL_ADDR (CTRL_ADDR)
      ) u_dec (
         .clk    (clk),
         .rst    (rst),
         .sel_n  (sel_n_v[p]),
         .mem_en (mem_en_v[p]),
         .addr   (addr_v[p]),
         .stb    (stb_v[p]),
         .region (region),
         .idx    (idx_v[p])
      );

      assign own_v[p]  = (region == RG_OWN);
      assign peer_v[p] = (region == RG_PEER);
      assign ctrl_v[p] = (region == RG_CTRL);
      assign resv_v[p] = (region == RG_RESV);

      assign box_we  = stb_v[p] & wr_v[p] & own_v[p];
      assign mask_we = stb_v[p] & wr_v[p] & ctrl_v[p] & lb_v[p];

      // Sources of this side are raised by the other side's upper-byte writes.
      assign set_ev = stb_v[Q] & wr_v[Q] & own_v[Q] & ub_v[Q];
      assign clr_ev = stb_v[p] & ~wr_v[p] & peer_v[p] & ub_v[p];

      mbx_store #(
         .DATA_W  (DATA_W),
         .NUM_BOX (NUM_BOX),
         .IDX_W   (IDX_W)
      ) u_store (
         .clk     (clk),
         .rst     (rst),
         .we      (box_we),
         .idx     (idx_v[p]),
         .half_en ({ub_v[p], lb_v[p]}),
         .wdata   (wdata_v[p]),
         .boxes   (box_v[p])
      );

      mbx_irq_bank #(
         .NUM_BOX (NUM_BOX),
         .IDX_W   (IDX_W)
      ) u_irq (
         .clk     (clk),
         .rst     (rst),
         .set_ev  (set_ev),
         .set_idx (idx_v[Q]),
         .clr_ev  (clr_ev),
         .clr_idx (idx_v[p]),
         .mask_we (mask_we),
         .mask_d  (wdata_v[p][NUM_BOX-1:0]),
         .mask    (mask_v[p]),
         .cause   (cause_v[p]),
         .stat    (stat_v[p])
      );

      always_comb begin
         ctrl_word = '0;
         ctrl_word[NUM_BOX-1:0]           = mask_v[p];
         ctrl_word[2*NUM_BOX-1:NUM_BOX]   = ~cause_v[p];
         ctrl_word[3*NUM_BOX-1:2*NUM_BOX] = ~stat_v[p];
      end

      always_comb begin
         rd_word = '0;
         if (!wr_v[p]) begin
            if (own_v[p])       rd_word = box_v[p][idx_v[p]];
            else if (peer_v[p]) rd_word = box_v[Q][idx_v[p]];
            else if (ctrl_v[p]) rd_word = ctrl_word;
         end
      end

      assign rd_v[p]    = rd_word;
      assign irq_n_v[p] = ~|cause_v[p];
   end

   assign a_rdata = rd_v[0];
   assign b_rdata = rd_v[1];
   assign a_irq_n = irq_n_v[0];
   assign b_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
   parameter int DATA_W  = 16,
   parameter int NUM_BOX = 4,
   parameter int IDX_W   = 2
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          a_sel_n,
   input logic                          a_irq_n,
   input logic                          b_irq_n,
   input logic [1:0]                    stb_v,
   input logic [1:0]                    wr_v,
   input logic [1:0]                    own_v,
   input logic [1:0]                    peer_v,
   input logic [1:0]                    resv_v,
   input logic [1:0]                    ub_v,
   input logic [1:0][IDX_W-1:0]         idx_v,
   input logic [1:0][NUM_BOX-1:0]       mask_v,
   input logic [1:0][NUM_BOX-1:0]       cause_v,
   input logic [1:0][NUM_BOX-1:0]       stat_v,
   input logic [1:0][NUM_BOX-1:0][DATA_W-1:0] box_v
);

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   // R11: one cycle after reset, masks are set and nothing is pending.
   always @(posedge clk) begin
      if (rst_q === 1'b1) begin
         assert_reset_state_R11: assert (a_irq_n && b_irq_n &&
                                         (&mask_v[0]) && (&mask_v[1]) &&
                                         stat_v == '0)
            else $error("reset state wrong");
      end
   end

   // R3: an unmasked upper-byte write from A raises B's interrupt.
   assert_set_raises_R3: assert property (@(posedge clk) disable iff (rst)
      (stb_v[0] && wr_v[0] && own_v[0] && ub_v[0] && !mask_v[1][idx_v[0]])
      |=> !b_irq_n);

   // R4: A reading its own mailbox leaves B's interrupt state alone.
   assert_ownread_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      (stb_v[0] && !wr_v[0] && own_v[0] && !stb_v[1])
      |=> ($stable(cause_v[1]) && $stable(stat_v[1])));

   // R6: with select held low, no further mailbox or mask change on A.
   assert_no_repeat_R6: assert property (@(posedge clk) disable iff (rst)
      (!a_sel_n && !stb_v[0]) |=> ($stable(box_v[0]) && $stable(mask_v[0])));

   // R9: a reserved write on A changes neither A's mailboxes nor its mask.
   assert_reserved_inert_R9: assert property (@(posedge clk) disable iff (rst)
      (stb_v[0] && resv_v[0]) |=> ($stable(box_v[0]) && $stable(mask_v[0])));

   // R10: A's interrupt can only fall after an upper-byte write from B.
   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(a_irq_n) |-> $past(stb_v[1] && wr_v[1] && own_v[1] && ub_v[1]));

   // R5: a lone acknowledge by B clears that status bit.
   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (stb_v[1] && !wr_v[1] && peer_v[1] && ub_v[1] && !stb_v[0])
      |=> !stat_v[1][$past(idx_v[1])]);

   // R12: a set and an acknowledge on the same B source keep it pending.
   assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
      (stb_v[0] && wr_v[0] && own_v[0] && ub_v[0] &&
       stb_v[1] && !wr_v[1] && peer_v[1] && ub_v[1] && idx_v[0] == idx_v[1])
      |=> stat_v[1][$past(idx_v[1])]);

endmodule

bind mbx_pair mbx_pair_chk #(
   .DATA_W  (DATA_W),
   .NUM_BOX (NUM_BOX),
   .IDX_W   (IDX_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .a_sel_n (a_sel_n),
   .a_irq_n (a_irq_n),
   .b_irq_n (b_irq_n),
   .stb_v   (stb_v),
   .wr_v    (wr_v),
   .own_v   (own_v),
   .peer_v  (peer_v),
   .resv_v  (resv_v),
   .ub_v    (ub_v),
   .idx_v   (idx_v),
   .mask_v  (mask_v),
   .cause_v (cause_v),
   .stat_v  (stat_v),
   .box_v   (box_v)
);

// File: tb/mbx_pair_test.sv
module mbx_pair_test;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        side;
      logic        men;
      logic [5:0]  addr;
      logic        wr;
      logic        ub;
      logic        lb;
      logic [15:0] wd;
      logic        chk;
      logic [15:0] exp;
      logic        ea;
      logic        eb;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,6'h28,1'b1,1'b0,1'b1,16'h0000,1'b0,16'h0000,1'b1,1'b1,4'd7},  // R7 A unmask
      '{1'b1,1'b0,6'h28,1'b1,1'b0,1'b1,16'h0000,1'b0,16'h0000,1'b1,1'b1,4'd7},  // R7 B unmask
      '{1'b0,1'b0,6'h20,1'b1,1'b1,1'b1,16'h1234,1'b0,16'h0000,1'b1,1'b0,4'd3},  // R3 raise B src0
      '{1'b0,1'b0,6'h20,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h1234,1'b1,1'b0,4'd4},  // R4 own readback
      '{1'b1,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0EE0,1'b1,1'b0,4'd7},  // R7 cause/status
      '{1'b1,1'b0,6'h24,1'b0,1'b0,1'b1,16'h0000,1'b1,16'h1234,1'b1,1'b0,4'd5},  // R5 low read no ack
      '{1'b1,1'b0,6'h24,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h1234,1'b1,1'b1,4'd5},  // R5 ack
      '{1'b1,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0FF0,1'b1,1'b1,4'd5},  // R5 bits cleared
      '{1'b1,1'b0,6'h22,1'b1,1'b0,1'b1,16'h00AB,1'b0,16'h0000,1'b1,1'b1,4'd3},  // R3 lower only
      '{1'b0,1'b0,6'h26,1'b0,1'b0,1'b1,16'h0000,1'b1,16'h00AB,1'b1,1'b1,4'd2},  // R2 low half
      '{1'b1,1'b0,6'h22,1'b1,1'b1,1'b0,16'hCD00,1'b0,16'h0000,1'b0,1'b1,4'd10}, // R10 irq A
      '{1'b0,1'b0,6'h26,1'b0,1'b1,1'b0,16'h0000,1'b1,16'hCDAB,1'b1,1'b1,4'd2},  // R2 merged
      '{1'b0,1'b0,6'h28,1'b1,1'b0,1'b1,16'h0008,1'b0,16'h0000,1'b1,1'b1,4'd8},  // R8 mask src3
      '{1'b1,1'b0,6'h23,1'b1,1'b1,1'b1,16'h5555,1'b0,16'h0000,1'b1,1'b1,4'd8},  // R8 masked set
      '{1'b0,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h07F8,1'b1,1'b1,4'd8},  // R8 status only
      '{1'b0,1'b0,6'h28,1'b1,1'b0,1'b1,16'h0000,1'b0,16'h0000,1'b1,1'b1,4'd8},  // R8 unmask
      '{1'b0,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h07F0,1'b1,1'b1,4'd8},  // R8 no cause
      '{1'b0,1'b0,6'h29,1'b1,1'b1,1'b1,16'hFFFF,1'b0,16'h0000,1'b1,1'b1,4'd9},  // R9 resv write
      '{1'b0,1'b0,6'h10,1'b1,1'b1,1'b1,16'hFFFF,1'b0,16'h0000,1'b1,1'b1,4'd9},  // R9 resv write
      '{1'b0,1'b0,6'h29,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0000,1'b1,1'b1,4'd9},  // R9 resv read
      '{1'b0,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h07F0,1'b1,1'b1,4'd9},  // R9 ctrl intact
      '{1'b0,1'b0,6'h27,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h5555,1'b1,1'b1,4'd5},  // R5 ack masked
      '{1'b0,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0FF0,1'b1,1'b1,4'd5},  // R5 cleared
      '{1'b0,1'b1,6'h20,1'b1,1'b1,1'b1,16'hFFFF,1'b0,16'h0000,1'b1,1'b1,4'd1},  // R1 mem enabled
      '{1'b0,1'b0,6'h20,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h1234,1'b1,1'b1,4'd1},  // R1 unchanged
      '{1'b0,1'b1,6'h20,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0000,1'b1,1'b1,4'd1},  // R1 read zero
      '{1'b1,1'b0,6'h28,1'b1,1'b1,1'b0,16'hFFFF,1'b0,16'h0000,1'b1,1'b1,4'd7},  // R7 needs lb
      '{1'b1,1'b0,6'h28,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h0FF0,1'b1,1'b1,4'd7},  // R7 mask kept
      '{1'b0,1'b0,6'h21,1'b1,1'b1,1'b0,16'h9900,1'b0,16'h0000,1'b1,1'b0,4'd3},  // R3 raise src1
      '{1'b1,1'b0,6'h25,1'b0,1'b1,1'b1,16'h0000,1'b1,16'h9900,1'b1,1'b1,4'd5},  // R5 ack src1
      '{1'b0,1'b0,6'h21,1'b1,1'b0,1'b1,16'h0011,1'b0,16'h0000,1'b1,1'b1,4'd3},  // R3 lower only
      '{1'b1,1'b0,6'h25,1'b0,1'b0,1'b1,16'h0000,1'b1,16'h9911,1'b1,1'b1,4'd2}   // R2 byte merge
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        a_sel_n, a_mem_en, a_wr, a_ub, a_lb, a_irq_n;
   logic        b_sel_n, b_mem_en, b_wr, b_ub, b_lb, b_irq_n;
   logic [5:0]  a_addr, b_addr;
   logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_pair uut (
      .clk(clk), .rst(rst),
      .a_sel_n(a_sel_n), .a_mem_en(a_mem_en), .a_addr(a_addr), .a_wr(a_wr),
      .a_ub(a_ub), .a_lb(a_lb), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
      .b_sel_n(b_sel_n), .b_mem_en(b_mem_en), .b_addr(b_addr), .b_wr(b_wr),
      .b_ub(b_ub), .b_lb(b_lb), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic side, input logic men, input logic [5:0] ad,
                        input logic w, input logic u, input logic l, input logic [15:0] wd);
      if (side == 1'b0) begin
         a_sel_n = 1'b0; a_mem_en = men; a_addr = ad; a_wr = w;
         a_ub = u; a_lb = l; a_wdata = wd;
      end else begin
         b_sel_n = 1'b0; b_mem_en = men; b_addr = ad; b_wr = w;
         b_ub = u; b_lb = l; b_wdata = wd;
      end
   endtask

   task automatic release_sel();
      a_sel_n = 1'b1; b_sel_n = 1'b1; a_mem_en = 1'b0; b_mem_en = 1'b0;
      a_wr = 1'b0; b_wr = 1'b0;
   endtask

   // One access: select falls at a negedge, data sampled mid-cycle,
   // select rises at the following negedge (after the acting edge).
   task automatic op(input logic side, input logic men, input logic [5:0] ad,
                     input logic w, input logic u, input logic l, input logic [15:0] wd,
                     output logic [15:0] rd);
      @(negedge clk);
      drive(side, men, ad, w, u, l, wd);
      #1;
      rd = (side == 1'b0) ? a_rdata : b_rdata;
      @(negedge clk);
      release_sel();
   endtask

   task automatic ctrl_read(input logic side, output logic [15:0] rd);
      op(side, 1'b0, 6'h28, 1'b0, 1'b1, 1'b1, 16'h0000, rd);
   endtask

   initial begin
      int unsigned cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      logic [15:0] rd;
      rst = 1'b1;
      a_addr = '0; b_addr = '0; a_ub = 1'b0; a_lb = 1'b0; b_ub = 1'b0; b_lb = 1'b0;
      a_wdata = '0; b_wdata = '0;
      release_sel();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R11: reset state at the ports
      check("R11 a_irq_n", {15'd0, a_irq_n}, 16'h0001);
      check("R11 b_irq_n", {15'd0, b_irq_n}, 16'h0001);
      ctrl_read(1'b0, rd);
      check("R11 A ctrl", rd, 16'h0FFF);
      ctrl_read(1'b1, rd);
      check("R11 B ctrl", rd, 16'h0FFF);

      // Table walk
      for (int k = 0; k < NV; k++) begin
         string tag;
         op(TBL[k].side, TBL[k].men, TBL[k].addr, TBL[k].wr, TBL[k].ub, TBL[k].lb,
            TBL[k].wd, rd);
         tag = $sformatf("R%0d vec%0d", TBL[k].req, k);
         if (TBL[k].chk) check({tag, " rdata"}, rd, TBL[k].exp);
         check({tag, " a_irq_n"}, {15'd0, a_irq_n}, {15'd0, TBL[k].ea});
         check({tag, " b_irq_n"}, {15'd0, b_irq_n}, {15'd0, TBL[k].eb});
      end

      // R6: address moved to the ack location while select stays low
      op(1'b0, 1'b0, 6'h20, 1'b1, 1'b1, 1'b1, 16'h4321, rd);
      check("R6 setup b_irq_n", {15'd0, b_irq_n}, 16'h0000);
      @(negedge clk);
      drive(1'b1, 1'b0, 6'h20, 1'b0, 1'b1, 1'b1, 16'h0000);
      @(negedge clk);
      drive(1'b1, 1'b0, 6'h24, 1'b0, 1'b1, 1'b1, 16'h0000);
      @(negedge clk);
      @(negedge clk);
      check("R6 held select no ack", {15'd0, b_irq_n}, 16'h0000);
      release_sel();
      op(1'b1, 1'b0, 6'h24, 1'b0, 1'b1, 1'b1, 16'h0000, rd);
      check("R6 fresh fall acks", {15'd0, b_irq_n}, 16'h0001);

      // R12: set and acknowledge of B source 2 in the same cycle
      op(1'b0, 1'b0, 6'h22, 1'b1, 1'b1, 1'b1, 16'h6600, rd);
      check("R12 setup b_irq_n", {15'd0, b_irq_n}, 16'h0000);
      @(negedge clk);
      drive(1'b0, 1'b0, 6'h22, 1'b1, 1'b1, 1'b0, 16'h7700);
      drive(1'b1, 1'b0, 6'h26, 1'b0, 1'b1, 1'b1, 16'h0000);
      @(negedge clk);
      release_sel();
      check("R12 set wins irq", {15'd0, b_irq_n}, 16'h0000);
      ctrl_read(1'b1, rd);
      check("R12 set wins ctrl", rd, 16'h0BB0);
      op(1'b1, 1'b0, 6'h26, 1'b0, 1'b1, 1'b1, 16'h0000, rd);
      check("R12 later ack data", rd, 16'h7700);
      check("R12 later ack irq", {15'd0, b_irq_n}, 16'h0001);

      // R11: reset in mid-run clears masks and mailboxes
      op(1'b1, 1'b0, 6'h20, 1'b1, 1'b1, 1'b1, 16'hBEEF, rd);
      check("R11 pre-reset a_irq_n", {15'd0, a_irq_n}, 16'h0000);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R11 post a_irq_n", {15'd0, a_irq_n}, 16'h0001);
      ctrl_read(1'b0, rd);
      check("R11 post A ctrl", rd, 16'h0FFF);
      op(1'b1, 1'b0, 6'h20, 1'b0, 1'b1, 1'b1, 16'h0000, rd);
      check("R11 post B box0", rd, 16'h0000);
      op(1'b1, 1'b0, 6'h20, 1'b1, 1'b1, 1'b1, 16'h1111, rd);
      check("R11 masked after reset", {15'd0, a_irq_n}, 16'h0001);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule